// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two byte-wide buses, called A and B, through a bidirectional transceiver. Each transfer direction has its own storage register. A forward path carries A towards B, and a reverse path carries B towards A. For each driven side, a per-direction select picks one of two sources: the live value on the opposite bus, or the word held in that direction's register. Each direction also has its own output enable. The forward enable is active high and the reverse enable is active low.

On-chip tri-state pins are not used. Each bus side instead brings out a data vector and an output-enable vector. The enable vector is replicated across all bit lanes. An external driver on each bus is modelled as a separate enable plus data input, so a surrounding fabric or a bench can play the far end. Inside the block, a resolver turns the external driver, the core's own drive and a per-lane bus keeper into one resolved value per bus. Both registers capture from those resolved values.

Everything runs on one clock. Each direction's capture edge is a capture strobe sampled on `clk`. A capture takes place on every edge where its strobe is high, whatever the selects and enables are set to. When both directions are enabled in live mode and no external driver is present, each bus would feed the other with no register in between. The keeper stands in for that loop, so both buses hold their last value.

Top module: `xcvr_dual_reg`

## Requirements
- R1: A synchronous active-low reset clears both direction registers and both bus keepers to zero. After reset, an undriven bus reads 0, and each register, made visible by setting its stored select to 1, reads 0.
- R2: When `fwd_cap` is 1 at a clock edge, the forward register takes the resolved A bus value. This holds even while B is not driven. When `fwd_cap` is 0, the forward register keeps its word.
- R3: When `rev_cap` is 1 at a clock edge, the reverse register takes the resolved B bus value. This holds even while A is not driven. When `rev_cap` is 0, the reverse register keeps its word.
- R4: `b_drv_oe` is all ones when `fwd_en` is 1 and all zeros when it is 0. `a_drv_oe` is all ones when `rev_en_n` is 0 and all zeros when it is 1.
- R5: `b_drv_data` equals the resolved A bus when `fwd_stored` is 0, and the forward register when it is 1. `a_drv_data` equals the resolved B bus when `rev_stored` is 0, and the reverse register when it is 1.
- R6: When a bus's external enable is 1, that bus resolves to the external data, whatever the core drives.
- R7: A bus with neither an external driver nor core drive keeps the value it resolved to on the previous clock.
- R8: With `fwd_en`=1, `rev_en_n`=0, both stored selects at 0 and no external driver, both buses hold the value A had on the previous clock and stay stable.
- R9: A single edge can write one bus into both registers, by pulsing both strobes while live mode copies that bus onto the other. The A word is copied with `fwd_en`=1, `fwd_stored`=0 and `rev_en_n`=1. The B word is copied with `rev_en_n`=0, `rev_stored`=0 and `fwd_en`=0.
- R10: With `fwd_en`=1, `rev_en_n`=0 and both stored selects at 1, B shows the forward register and A shows the reverse register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both registers and keepers |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_cap | input | 1 | Capture strobe for the A-to-B register |
| rev_cap | input | 1 | Capture strobe for the B-to-A register |
| fwd_en | input | 1 | Drive B from the forward path, active high |
| rev_en_n | input | 1 | Drive A from the reverse path, active low |
| fwd_stored | input | 1 | Forward source: 0 selects live A, 1 selects the stored word |
| rev_stored | input | 1 | Reverse source: 0 selects live B, 1 selects the stored word |
| a_ext_en | input | 1 | An external driver is active on bus A |
| a_ext_data | input | 8 | External driver value on bus A |
| b_ext_en | input | 1 | An external driver is active on bus B |
| b_ext_data | input | 8 | External driver value on bus B |
| a_drv_data | output | 8 | Value the core offers to bus A |
| a_drv_oe | output | 8 | Per-lane enable of the core's drive onto A |
| b_drv_data | output | 8 | Value the core offers to bus B |
| b_drv_oe | output | 8 | Per-lane enable of the core's drive onto B |
| a_bus | output | 8 | Resolved value of bus A |
| b_bus | output | 8 | Resolved value of bus B |

## Verification
The live loop hold is the hardest case to reach. To reach it, a bus has to be driven externally while both directions are enabled in live mode. The external driver then has to withdraw, and the bench must confirm that both buses keep that value over several edges with no register feeding them. The directed sequence builds this state step by step. The random phase reaches it again from arbitrary keeper contents, because it toggles the external enables with even odds.

Capture while a direction is disabled is the next hardest case, since nothing at the ports shows the register at that moment. The bench captures under isolation. It then switches to stored mode with the strobes low and reads the word back through the driven bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned BUS_W = 8;

  typedef struct packed {
    logic drv_a;   // core drives bus A
    logic drv_b;   // core drives bus B
    logic live_a;  // A is driven with live B data
    logic live_b;  // B is driven with live A data
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl (
  input  logic                  fwd_en,
  input  logic                  rev_en_n,
  input  logic                  fwd_stored,
  input  logic                  rev_stored,
  output xcvr_pkg::xcvr_ctrl_t  ctrl
);
  always_comb begin
    ctrl.drv_b  = fwd_en;
    ctrl.drv_a  = ~rev_en_n;
    ctrl.live_b = fwd_en & ~fwd_stored;
    ctrl.live_a = ~rev_en_n & ~rev_stored;
  end
endmodule

// File: rtl/xcvr_slice.sv
module xcvr_slice (
  input  logic                  clk,
  input  logic                  rst_n,
  input  xcvr_pkg::xcvr_ctrl_t  ctrl,
  input  logic                  fwd_stored,
  input  logic                  rev_stored,
  input  logic                  fwd_cap,
  input  logic                  rev_cap,
  input  logic                  a_ext_en,
  input  logic                  a_ext,
  input  logic                  b_ext_en,
  input  logic                  b_ext,
  output logic                  a_res,
  output logic                  b_res,
  output logic                  a_core,
  output logic                  b_core
);
  logic fwd_q, rev_q, keep_a, keep_b;
  logic a_solo, b_solo, a_fed, b_fed, loop_ne;

  always_comb begin
    // value of each bus from every source except a live feed
    a_solo  = a_ext_en ? a_ext : ((ctrl.drv_a & rev_stored) ? rev_q : keep_a);
    b_solo  = b_ext_en ? b_ext : ((ctrl.drv_b & fwd_stored) ? fwd_q : keep_b);
    a_fed   = ctrl.live_a & ~a_ext_en;
    b_fed   = ctrl.live_b & ~b_ext_en;
    loop_ne = a_fed & b_fed;
    if (loop_ne) begin
      a_res = keep_a;
      b_res = keep_a;
    end else if (a_fed) begin
      a_res = b_solo;
      b_res = b_solo;
    end else if (b_fed) begin
      a_res = a_solo;
      b_res = a_solo;
    end else begin
      a_res = a_solo;
      b_res = b_solo;
    end
    a_core = rev_stored ? rev_q : b_res;
    b_core = fwd_stored ? fwd_q : a_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q  <= 1'b0;
      rev_q  <= 1'b0;
      keep_a <= 1'b0;
      keep_b <= 1'b0;
    end else begin
      if (fwd_cap) fwd_q <= a_res;
      if (rev_cap) rev_q <= b_res;
      keep_a <= a_res;
      keep_b <= b_res;
    end
  end

  p_fwd_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_cap |=> (fwd_q == $past(a_res)));
  p_fwd_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_cap |=> $stable(fwd_q));
  p_rev_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rev_cap |=> (rev_q == $past(b_res)));
  p_rev_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_cap |=> $stable(rev_q));
  p_ext_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ext_en |-> a_res == a_ext) and (b_ext_en |-> b_res == b_ext));
  p_loop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_ne && $past(loop_ne)) |-> (a_res == $past(a_res) && b_res == a_res));
endmodule

// File: rtl/xcvr_dual_reg.sv
module xcvr_dual_reg #(
  parameter int unsigned DATA_W = xcvr_pkg::BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_cap,
  input  logic              rev_cap,
  input  logic              fwd_en,
  input  logic              rev_en_n,
  input  logic              fwd_stored,
  input  logic              rev_stored,
  input  logic              a_ext_en,
  input  logic [DATA_W-1:0] a_ext_data,
  input  logic              b_ext_en,
  input  logic [DATA_W-1:0] b_ext_data,
  output logic [DATA_W-1:0] a_drv_data,
  output logic [DATA_W-1:0] a_drv_oe,
  output logic [DATA_W-1:0] b_drv_data,
  output logic [DATA_W-1:0] b_drv_oe,
  output logic [DATA_W-1:0] a_bus,
  output logic [DATA_W-1:0] b_bus
);
  localparam int unsigned LANES = DATA_W;

  xcvr_pkg::xcvr_ctrl_t ctrl;

  xcvr_ctrl ctrl_i (
    .fwd_en     (fwd_en),
    .rev_en_n   (rev_en_n),
    .fwd_stored (fwd_stored),
    .rev_stored (rev_stored),
    .ctrl       (ctrl)
  );

  assign a_drv_oe = {LANES{ctrl.drv_a}};
  assign b_drv_oe = {LANES{ctrl.drv_b}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    xcvr_slice slice_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl       (ctrl),
      .fwd_stored (fwd_stored),
      .rev_stored (rev_stored),
      .fwd_cap    (fwd_cap),
      .rev_cap    (rev_cap),
      .a_ext_en   (a_ext_en),
      .a_ext      (a_ext_data[i]),
      .b_ext_en   (b_ext_en),
      .b_ext      (b_ext_data[i]),
      .a_res      (a_bus[i]),
      .b_res      (b_bus[i]),
      .a_core     (a_drv_data[i]),
      .b_core     (b_drv_data[i])
    );
  end

  p_fwd_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en ? (b_drv_oe == {LANES{1'b1}}) : (b_drv_oe == '0));
  p_rev_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rev_en_n ? (a_drv_oe == '0) : (a_drv_oe == {LANES{1'b1}}));
  p_stored_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && !rev_en_n && fwd_stored && rev_stored && !a_ext_en && !b_ext_en)
      |-> (a_bus == a_drv_data && b_bus == b_drv_data));
  p_live_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && !fwd_stored && !b_ext_en) |-> (b_bus == a_bus));
endmodule

// File: tb/xcvr_dual_reg_tb.sv
module xcvr_dual_reg_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_cap = 0, rev_cap = 0, fwd_en = 0, rev_en_n = 1, fwd_stored = 0, rev_stored = 0;
  logic a_ext_en = 0, b_ext_en = 0;
  logic [W-1:0] a_ext_data = '0, b_ext_data = '0;
  logic [W-1:0] a_drv_data, a_drv_oe, b_drv_data, b_drv_oe, a_bus, b_bus;

  logic [W-1:0] m_fwd = '0, m_rev = '0, m_ka = '0, m_kb = '0;
  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  xcvr_dual_reg dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_cap(fwd_cap), .rev_cap(rev_cap),
    .fwd_en(fwd_en), .rev_en_n(rev_en_n), .fwd_stored(fwd_stored), .rev_stored(rev_stored),
    .a_ext_en(a_ext_en), .a_ext_data(a_ext_data), .b_ext_en(b_ext_en), .b_ext_data(b_ext_data),
    .a_drv_data(a_drv_data), .a_drv_oe(a_drv_oe), .b_drv_data(b_drv_data), .b_drv_oe(b_drv_oe),
    .a_bus(a_bus), .b_bus(b_bus)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected bus values from the requirement rules (R6, R7, R8, R5)
  task automatic expect_bus(output logic [W-1:0] ea, output logic [W-1:0] eb, output string tag);
    logic a_fed, b_fed;
    logic [W-1:0] a_solo, b_solo;
    a_fed = !rev_en_n && !rev_stored && !a_ext_en;
    b_fed = fwd_en && !fwd_stored && !b_ext_en;
    a_solo = a_ext_en ? a_ext_data : ((!rev_en_n && rev_stored) ? m_rev : m_ka);
    b_solo = b_ext_en ? b_ext_data : ((fwd_en && fwd_stored) ? m_fwd : m_kb);
    tag = (a_ext_en || b_ext_en) ? "R6" : "R7";
    if (a_fed && b_fed) begin ea = m_ka; eb = m_ka; tag = "R8"; end
    else if (a_fed) begin ea = b_solo; eb = b_solo; tag = "R5"; end
    else if (b_fed) begin ea = a_solo; eb = a_solo; tag = "R5"; end
    else begin ea = a_solo; eb = b_solo; end
  endtask

  // Called with inputs set just after a falling edge; checks, then advances one clock
  task automatic step();
    logic [W-1:0] ea, eb, n_fwd, n_rev;
    string tag;
    #1;
    expect_bus(ea, eb, tag);
    if (rst_n) begin
      check(tag, "a_bus", a_bus, ea);
      check(tag, "b_bus", b_bus, eb);
      check("R5", "a_drv_data", a_drv_data, rev_stored ? m_rev : eb);
      check("R5", "b_drv_data", b_drv_data, fwd_stored ? m_fwd : ea);
      check("R4", "a_drv_oe", a_drv_oe, {W{~rev_en_n}});
      check("R4", "b_drv_oe", b_drv_oe, {W{fwd_en}});
    end
    n_fwd = fwd_cap ? ea : m_fwd;
    n_rev = rev_cap ? eb : m_rev;
    @(posedge clk);
    if (!rst_n) begin
      m_fwd = '0; m_rev = '0; m_ka = '0; m_kb = '0;
    end else begin
      m_fwd = n_fwd; m_rev = n_rev; m_ka = ea; m_kb = eb;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    fwd_cap = 0; rev_cap = 0; fwd_en = 0; rev_en_n = 1;
    fwd_stored = 0; rev_stored = 0; a_ext_en = 0; b_ext_en = 0;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    step(); step();
    rst_n = 1;
    // R1: reset state
    fwd_stored = 1; rev_stored = 1;
    #1;
    check("R1", "a_bus after reset", a_bus, '0);
    check("R1", "b_bus after reset", b_bus, '0);
    check("R1", "reverse register", a_drv_data, '0);
    check("R1", "forward register", b_drv_data, '0);
    step();
    // R2: capture A while both directions isolated
    quiet(); a_ext_en = 1; a_ext_data = 8'h5A; fwd_cap = 1;
    step();
    quiet(); fwd_en = 1; fwd_stored = 1;
    #1 check("R2", "stored A after isolated capture", b_bus, 8'h5A);
    check("R7", "undriven A keeps value", a_bus, 8'h5A);
    step();
    // R3: capture B while A released
    quiet(); b_ext_en = 1; b_ext_data = 8'hC3; rev_cap = 1;
    step();
    quiet(); rev_en_n = 0; rev_stored = 1;
    #1 check("R3", "stored B on A", a_bus, 8'hC3);
    check("R4", "b released", b_drv_oe, '0);
    check("R4", "a driven", a_drv_oe, 8'hFF);
    step();
    // R5: live A to B
    quiet(); fwd_en = 1; a_ext_en = 1; a_ext_data = 8'h96;
    #1 check("R5", "live A on B", b_bus, 8'h96);
    step();
    // R10: both registers loaded with different words, shown together
    quiet(); a_ext_en = 1; a_ext_data = 8'h11; b_ext_en = 1; b_ext_data = 8'hEE;
    fwd_cap = 1; rev_cap = 1;
    step();
    quiet(); fwd_en = 1; rev_en_n = 0; fwd_stored = 1; rev_stored = 1;
    #1 check("R10", "stored B on A", a_bus, 8'hEE);
    check("R10", "stored A on B", b_bus, 8'h11);
    step();
    // R9: A into both registers
    quiet(); fwd_en = 1; a_ext_en = 1; a_ext_data = 8'h3C; fwd_cap = 1; rev_cap = 1;
    step();
    quiet(); fwd_en = 1; rev_en_n = 0; fwd_stored = 1; rev_stored = 1;
    #1 check("R9", "forward reg holds A", b_bus, 8'h3C);
    check("R9", "reverse reg holds A", a_bus, 8'h3C);
    step();
    // R9: B into both registers
    quiet(); rev_en_n = 0; b_ext_en = 1; b_ext_data = 8'h77; fwd_cap = 1; rev_cap = 1;
    step();
    quiet(); fwd_en = 1; rev_en_n = 0; fwd_stored = 1; rev_stored = 1;
    #1 check("R9", "forward reg holds B", b_bus, 8'h77);
    check("R9", "reverse reg holds B", a_bus, 8'h77);
    step();
    // R8: loop hold after external driver leaves
    quiet(); fwd_en = 1; rev_en_n = 0; a_ext_en = 1; a_ext_data = 8'hA5;
    step();
    a_ext_en = 0;
    for (int k = 0; k < 3; k++) begin
      #1 check("R8", "loop A", a_bus, 8'hA5);
      check("R8", "loop B", b_bus, 8'hA5);
      step();
    end
    // R6: external driver beats stored drive
    quiet(); fwd_en = 1; fwd_stored = 1; b_ext_en = 1; b_ext_data = 8'h0F;
    #1 check("R6", "external wins on B", b_bus, 8'h0F);
    step();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      rst_n      = ($urandom_range(0, 99) != 0);
      fwd_cap    = $urandom_range(0, 1);
      rev_cap    = $urandom_range(0, 1);
      fwd_en     = $urandom_range(0, 1);
      rev_en_n   = $urandom_range(0, 1);
      fwd_stored = $urandom_range(0, 1);
      rev_stored = $urandom_range(0, 1);
      a_ext_en   = $urandom_range(0, 1);
      b_ext_en   = $urandom_range(0, 1);
      a_ext_data = W'($urandom);
      b_ext_data = W'($urandom);
      step();
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule